// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block takes one configuration access from a host-side requester and turns it into the request packet that the root port sends downstream. A request carries a target bus, a device/function number, a byte address inside configuration space, an access size of one, two or four bytes, write data and a read/write flag. The block forms a three-dword header and, for writes, a data dword. It emits them as 64-bit beats on a valid/ready stream, with start-of-packet and end-of-packet flags.

The block keeps the root bus number itself. From that number it chooses between a type 0 access (the root bus) and a type 1 access (any other bus), and it uses the number as the requester ID. The number is updated when software writes the primary-bus register of the root port. Some requests are refused before anything is emitted: devices other than 0 on the root bus, the root port's first base address register, and any request for a downstream bus while the link is down. A refused request is reported through a one-cycle reject pulse that carries a code.

Top module: `cfg_tlp_packer`

## Requirements
- R1: The header type byte is 0x04 for a read and 0x44 for a write when the target bus equals the stored root bus. On any other bus it is 0x05 for a read and 0x45 for a write.
- R2: Header dword 0 is the type byte in bits 31:24 with the value 1 in bits 23:0.
- R3: Header dword 1 holds the root bus number in bits 31:24, zero in bits 23:16, the tag in bits 15:8 (0x1D for a read, 0x10 for a write) and the byte enables in bits 3:0.
- R4: With req_size 0 (one byte) the byte enables are 1<<addr[1:0]. With req_size 1 (two bytes) they are 3<<addr[1:0], truncated to 4 bits. With req_size 2 or 3 (four bytes) they are 0xF.
- R5: Header dword 2 holds the bus in bits 31:24 and devfn in bits 23:16. Bits 15:0 hold the byte address with bits 1:0 cleared.
- R6: Write data is first masked to the access size. One- and two-byte data is then shifted left by 8*addr[1:0]; four-byte data is not shifted. Read requests carry zero data.
- R7: The first beat holds dword 0 in bits 31:0 and dword 1 in bits 63:32, with SOP set. A write with addr[2:0]==0 takes three beats. The second beat holds dword 2 in its low half and zero in its high half, with no flags. The third beat holds the data in its low half and zero in its high half, with EOP set.
- R8: Every read, and every write with addr[2:0]!=0, takes two beats. The second beat holds dword 2 in its low half and the data in its high half, with EOP set. No beat has both SOP and EOP set.
- R9: A beat stays on the output, unchanged, until out_ready is seen with it.
- R10: req_ready is low from the cycle after an accepted request until the final beat has been taken. After the final beat out_valid drops.
- R11: A request on the root bus is refused without any beat. Address 0x10 with devfn 0 gives code 2; devfn[7:3] non-zero gives code 1. The rej_valid pulse rises in the cycle after the request is accepted.
- R12: A request for any other bus while link_up is low is refused with code 1 and no beat. A request on the root bus is not affected by link_up.
- R13: When the final beat of a write on the root bus to byte address 0x18..0x1B is taken, the stored root bus number becomes bits 7:0 of the lane-shifted write data. It changes at no other time.
- R14: After reset, req_ready is 1, out_valid and rej_valid are 0, and root_bus equals ROOT_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2/3 four bytes |
| req_wdata | input | 32 | Write data, right-justified |
| link_up | input | 1 | Downstream link is up |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Beat taken |
| out_data | output | 64 | Beat payload |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| rej_valid | output | 1 | One-cycle reject pulse |
| rej_code | output | 2 | 1 no device, 2 bad register |
| root_bus | output | 8 | Stored root bus number |

## Verification
The bench applies irregular back-pressure and checks every beat against an independent model. A design that moved a beat early or lost a beat under a stall would fail those compares. It covers aligned against unaligned writes: if the alignment test were wrong, a write would come out with the wrong beat count, or its data would sit beside dword 2. It also covers narrow accesses at the top lane, where a bad shift or byte-enable shows up directly in the beats. Finally it rewrites the primary bus and then addresses both the old and the new root bus. A block that updated the number too early, took the wrong byte or kept the old value would pick the wrong type byte, requester ID or reject decision.

// File: rtl/cfgpk_pkg.sv
package cfgpk_pkg;
    localparam int DW_W      = 32;
    localparam int BEAT_W    = 2 * DW_W;
    localparam int MAX_BEATS = 3;
    localparam int IDX_W     = $clog2(MAX_BEATS);

    localparam logic [7:0] FMT_RD_LOCAL  = 8'h04;
    localparam logic [7:0] FMT_WR_LOCAL  = 8'h44;
    localparam logic [7:0] FMT_RD_REMOTE = 8'h05;
    localparam logic [7:0] FMT_WR_REMOTE = 8'h45;
    localparam logic [7:0] TAG_READ      = 8'h1D;
    localparam logic [7:0] TAG_WRITE     = 8'h10;

    typedef enum logic [1:0] {
        REJ_NONE   = 2'd0,
        REJ_NODEV  = 2'd1,
        REJ_BADREG = 2'd2
    } rej_e;

    typedef struct packed {
        logic [BEAT_W-1:0] data;
        logic              sop;
        logic              eop;
    } beat_t;

    function automatic logic [3:0] lane_enables(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            2'd0:    return 4'b0001 << lo;
            2'd1:    return 4'b0011 << lo;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [DW_W-1:0] lane_data(input logic [1:0] sz, input logic [1:0] lo,
                                                   input logic [DW_W-1:0] wd);
        case (sz)
            2'd0:    return {24'h0, wd[7:0]} << (8 * lo);
            2'd1:    return {16'h0, wd[15:0]} << (8 * lo);
            default: return wd;
        endcase
    endfunction
endpackage

// File: rtl/cfgpk_hdr.sv
module cfgpk_hdr
    import cfgpk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              wr,
    input  logic [7:0]        bus,
    input  logic [7:0]        devfn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DW_W-1:0]   wdata,
    input  logic [7:0]        root,
    input  logic              link_up,
    output beat_t             beats [MAX_BEATS],
    output logic [IDX_W-1:0]  last_idx,
    output rej_e              rej,
    output logic              prim_hit,
    output logic [7:0]        prim_val
);
    localparam int DW_ADDR_W = ADDR_W - 2;

    logic            on_root;
    logic [7:0]      fmt;
    logic [3:0]      be;
    logic [DW_W-1:0] data, dw0, dw1, dw2;
    logic [15:0]     offs;
    logic            aligned;

    always_comb begin
        on_root  = (bus == root);
        fmt      = wr ? (on_root ? FMT_WR_LOCAL : FMT_WR_REMOTE)
                      : (on_root ? FMT_RD_LOCAL : FMT_RD_REMOTE);
        be       = lane_enables(size, addr[1:0]);
        data     = wr ? lane_data(size, addr[1:0], wdata) : '0;
        offs     = 16'({addr[ADDR_W-1:2], 2'b00});
        dw0      = {fmt, 24'h000001};
        dw1      = {root, 8'h00, (wr ? TAG_WRITE : TAG_READ), 4'h0, be};
        dw2      = {bus, devfn, offs};
        aligned  = wr && (addr[2:0] == 3'b000);

        beats[0] = '{data: {dw1, dw0}, sop: 1'b1, eop: 1'b0};
        if (aligned) begin
            beats[1] = '{data: {32'h0, dw2},  sop: 1'b0, eop: 1'b0};
            beats[2] = '{data: {32'h0, data}, sop: 1'b0, eop: 1'b1};
            last_idx = IDX_W'(2);
        end else begin
            beats[1] = '{data: {data, dw2}, sop: 1'b0, eop: 1'b1};
            beats[2] = '0;
            last_idx = IDX_W'(1);
        end

        if (on_root && devfn == 8'h00 && addr == ADDR_W'(16'h10))
            rej = REJ_BADREG;
        else if (on_root && devfn[7:3] != 5'd0)
            rej = REJ_NODEV;
        else if (!on_root && !link_up)
            rej = REJ_NODEV;
        else
            rej = REJ_NONE;

        prim_hit = wr && on_root && (addr[ADDR_W-1:2] == DW_ADDR_W'(6));
        prim_val = data[7:0];
    end
endmodule

// File: rtl/cfgpk_seq.sv
module cfgpk_seq
    import cfgpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  beat_t            beats_in [MAX_BEATS],
    input  logic [IDX_W-1:0] last_in,
    input  logic             out_ready,
    output logic             busy,
    output beat_t            beat_out,
    output logic             done
);
    beat_t            store [MAX_BEATS];
    logic [IDX_W-1:0] idx, last;

    for (genvar i = 0; i < MAX_BEATS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                store[i] <= '0;
            else if (load)
                store[i] <= beats_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            last <= '0;
        end else if (load) begin
            busy <= 1'b1;
            idx  <= '0;
            last <= last_in;
        end else if (busy && out_ready) begin
            if (idx == last)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    assign beat_out = store[idx];
    assign done     = busy && out_ready && (idx == last);
endmodule

// File: rtl/cfgpk_root.sv
module cfgpk_root #(
    parameter logic [7:0] ROOT_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       prim_hit,
    input  logic [7:0] prim_val,
    input  logic       done,
    output logic [7:0] root
);
    logic       pend;
    logic [7:0] pend_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            root     <= ROOT_INIT;
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (load) begin
            pend     <= prim_hit;
            pend_val <= prim_val;
        end else if (done) begin
            pend <= 1'b0;
            if (pend)
                root <= pend_val;
        end
    end
endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
    import cfgpk_pkg::*;
#(
    parameter int         ADDR_W    = 12,
    parameter logic [7:0] ROOT_INIT = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [7:0]        req_bus,
    input  logic [7:0]        req_devfn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              link_up,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              rej_valid,
    output logic [1:0]        rej_code,
    output logic [7:0]        root_bus
);
    beat_t            beats [MAX_BEATS];
    beat_t            cur;
    logic [IDX_W-1:0] last_idx;
    rej_e             rej;
    logic             prim_hit, busy, done, accept, load;
    logic [7:0]       prim_val;

    cfgpk_hdr #(.ADDR_W(ADDR_W)) u_hdr (
        .wr(req_write), .bus(req_bus), .devfn(req_devfn), .addr(req_addr),
        .size(req_size), .wdata(req_wdata), .root(root_bus), .link_up(link_up),
        .beats(beats), .last_idx(last_idx), .rej(rej),
        .prim_hit(prim_hit), .prim_val(prim_val)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign load      = accept && (rej == REJ_NONE);

    cfgpk_seq u_seq (
        .clk(clk), .rst(rst), .load(load), .beats_in(beats), .last_in(last_idx),
        .out_ready(out_ready), .busy(busy), .beat_out(cur), .done(done)
    );

    cfgpk_root #(.ROOT_INIT(ROOT_INIT)) u_root (
        .clk(clk), .rst(rst), .load(load), .prim_hit(prim_hit),
        .prim_val(prim_val), .done(done), .root(root_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rej_valid <= 1'b0;
            rej_code  <= 2'd0;
        end else begin
            rej_valid <= accept && (rej != REJ_NONE);
            rej_code  <= (accept && rej != REJ_NONE) ? rej : REJ_NONE;
        end
    end

    assign out_valid = busy;
    assign out_data  = cur.data;
    assign out_sop   = cur.sop;
    assign out_eop   = cur.eop;
endmodule

// File: rtl/cfgpk_chk.sv
module cfgpk_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic        rej_valid,
    input logic [7:0]  root_bus
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    assert_drain_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_eop |=> !out_valid);

    assert_sop_first_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !out_eop |=> out_valid && !out_sop);

    assert_flags_apart_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));

    assert_reject_silent_R11: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> !out_valid);

    assert_root_change_R13: assert property (@(posedge clk) disable iff (rst)
        !$stable(root_bus) |-> $past(out_valid && out_ready && out_eop));
endmodule

bind cfg_tlp_packer cfgpk_chk u_chk (.*);

// File: tb/cfg_tlp_packer_test.sv
`timescale 1ns/1ps
module cfg_tlp_packer_test;
    typedef struct {
        bit          is_rej;
        logic [1:0]  code;
        logic [63:0] data;
        logic        sop;
        logic        eop;
        string       req;
    } exp_t;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0, link_up = 1, out_ready = 0;
    logic [7:0]  req_bus = 0, req_devfn = 0;
    logic [11:0] req_addr = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_wdata = 0;
    logic        req_ready, out_valid, out_sop, out_eop, rej_valid;
    logic [63:0] out_data;
    logic [1:0]  rej_code;
    logic [7:0]  root_bus;

    exp_t        q[$];
    int          checks = 0, errors = 0, cyc = 0;
    logic [7:0]  m_root = 8'h00;

    always #2.5 clk = ~clk;

    cfg_tlp_packer uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_beat(input logic [63:0] d, input logic s, input logic e, input string r);
        exp_t it;
        it.is_rej = 0; it.code = 0; it.data = d; it.sop = s; it.eop = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic push_rej(input logic [1:0] c, input string r);
        exp_t it;
        it.is_rej = 1; it.code = c; it.data = 0; it.sop = 0; it.eop = 0; it.req = r;
        q.push_back(it);
    endtask

    // Driver: computes expected items from the requirements, then presents the request.
    task automatic send(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [11:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input bit lk);
        bit          local_bus;
        logic [7:0]  fmt, tag;
        logic [3:0]  be;
        logic [31:0] d, d0, d1, d2;
        local_bus = (bus == m_root);
        if (local_bus && devfn == 0 && addr == 12'h010)
            push_rej(2'd2, "R11");
        else if (local_bus && devfn[7:3] != 0)
            push_rej(2'd1, "R11");
        else if (!local_bus && !lk)
            push_rej(2'd1, "R12");
        else begin
            fmt = local_bus ? (wr ? 8'h44 : 8'h04) : (wr ? 8'h45 : 8'h05);
            tag = wr ? 8'h10 : 8'h1D;
            if (sz == 0) be = 4'(1 << addr[1:0]);
            else if (sz == 1) be = 4'(3 << addr[1:0]);
            else be = 4'hF;
            if (!wr) d = 0;
            else if (sz == 0) d = (wd & 32'hFF) << (8 * addr[1:0]);
            else if (sz == 1) d = (wd & 32'hFFFF) << (8 * addr[1:0]);
            else d = wd;
            d0 = {fmt, 24'h1};
            d1 = {m_root, 8'h00, tag, 4'h0, be};
            d2 = {bus, devfn, 4'h0, addr[11:2], 2'b00};
            push_beat({d1, d0}, 1, 0, "R1 R2 R3 R4");
            if (wr && addr[2:0] == 0) begin
                push_beat({32'h0, d2}, 0, 0, "R5 R7");
                push_beat({32'h0, d}, 0, 1, "R6 R7");
            end else
                push_beat({d, d2}, 0, 1, "R5 R6 R8");
            if (wr && local_bus && addr[11:2] == 10'd6)
                m_root = d[7:0];
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_bus = bus; req_devfn = devfn; req_addr = addr;
        req_size = sz; req_wdata = wd; link_up = lk; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Monitor: sets back-pressure, then compares what the block produces (R9 under stalls).
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = !rst && ((cyc % 5) != 2) && ((cyc % 7) != 4);
            #1;
            if (!rst && out_valid)
                check(!req_ready, "R10", "req_ready while busy", {63'h0, req_ready}, 64'h0);
            if (!rst && rej_valid) begin
                if (q.size() == 0) check(0, "R11", "unexpected reject", {62'h0, rej_code}, 0);
                else begin
                    it = q.pop_front();
                    check(it.is_rej && rej_code == it.code, it.req, "reject code",
                          {62'h0, rej_code}, {62'h0, it.code});
                end
            end
            if (!rst && out_valid && out_ready) begin
                if (q.size() == 0) check(0, "R10", "unexpected beat", out_data, 0);
                else begin
                    it = q.pop_front();
                    check(!it.is_rej && out_data == it.data && out_sop == it.sop && out_eop == it.eop,
                          it.req, "beat", {out_data[63:2], out_sop, out_eop},
                          {it.data[63:2], it.sop, it.eop});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        check(req_ready === 1 && out_valid === 0 && rej_valid === 0 && root_bus === 8'h00,
              "R14", "reset state", {req_ready, out_valid, rej_valid, root_bus},
              {1'b1, 1'b0, 1'b0, 8'h00});

        send(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1);          // R1 R8 root read
        send(1, 8'h00, 8'h00, 12'h008, 2'd2, 32'hCAFE_F00D, 1);  // R7 aligned write
        send(1, 8'h03, 8'h21, 12'h00D, 2'd0, 32'h1234_56A5, 1);  // R4 R6 byte, type 1
        send(1, 8'h03, 8'h08, 12'h006, 2'd1, 32'hFFFF_BEEF, 1);  // R4 R6 half at lane 2
        send(0, 8'h07, 8'h10, 12'hFFF, 2'd0, 32'h0, 1);          // R5 top byte read
        send(1, 8'h07, 8'h10, 12'h0FB, 2'd0, 32'h0000_0077, 1);  // R6 top lane shift
        send(0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0, 1);          // R11 device 1
        send(0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 1);          // R11 bar
        send(0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 0);          // R12 link down
        send(0, 8'h00, 8'h00, 12'h004, 2'd2, 32'h0, 0);          // R12 root unaffected
        send(1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0005_0402, 1);  // R13 root becomes 2
        send(0, 8'h02, 8'h00, 12'h008, 2'd2, 32'h0, 0);          // R1 R13 new root, type 0
        send(0, 8'h00, 8'h00, 12'h008, 2'd2, 32'h0, 1);          // R1 old root now type 1
        send(0, 8'h02, 8'h18, 12'h000, 2'd2, 32'h0, 1);          // R11 on new root
        send(1, 8'h02, 8'h00, 12'h01A, 2'd1, 32'h0000_0009, 1);  // R13 half at 0x1A -> low byte 0
        send(1, 8'h00, 8'h00, 12'h014, 2'd2, 32'h0000_0055, 1);  // R13 other bus/offset: no change

        repeat (40) @(negedge clk);
        #1;
        check(q.size() == 0, "R10", "items left", q.size(), 0);
        check(root_bus === m_root, "R13", "root bus", {56'h0, root_bus}, {56'h0, m_root});
        check(out_valid === 0 && req_ready === 1, "R10", "idle at end",
              {62'h0, out_valid, req_ready}, 64'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule